// File: doc/BRIEF.md
# Idle-Mode Clock Gating Controller

This block sits beside the CPU core of a small microcontroller and decides, cycle by cycle, which clocks are allowed to run. It follows the software-visible clock-source select field while the core executes, picks one of two oscillators (a primary one and a slower secondary one), and turns a sleep-instruction strobe into an idle or a sleep state. In the idle states the CPU stops but the peripherals keep receiving a clock from whichever oscillator was selected when sleep executed. In the sleep state both enables drop.

A wake event ends any idle or sleep state. The CPU does not restart at once: the block holds the CPU enable low for a fixed number of cycles, set by a parameter, while the peripherals keep running. Execution then resumes on the oscillator that was in use during the idle period. The gating appears as synchronous enables rather than gated clocks. The block also drives an oscillator-enable for the primary source and two status flags that software reads to learn which oscillator is live.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset the mode output is 0, both clock enables are 1, the primary oscillator is enabled, the start-up-complete flag is 1 and the secondary-running flag is 0.
- R2: Mode output codes are 0 primary run, 1 secondary run, 2 primary idle, 3 secondary idle, 4 waking, 5 sleep. In a run mode without a sleep strobe, the next mode is 1 when the select field is 2'b01 and 0 for any other select value. Both clock enables are 1 in the run modes.
- R3: While the secondary oscillator is the source, the primary oscillator enable is 0, the start-up-complete flag is 0, the secondary-running flag is 1 and the peripheral source output is 1. While the primary is the source, all four take their opposite values.
- R4: A sleep strobe in a run mode with idle-enable 1 and a select value other than 2'b01 (and no wake) moves the block to mode 2. There the CPU enable is 0, the peripheral enable is 1, and the start-up-complete flag stays 1.
- R5: A sleep strobe in a run mode with idle-enable 1 and select 2'b01 (and no wake) moves the block to mode 3. There the CPU enable is 0 and the peripherals run from the secondary oscillator.
- R6: A sleep strobe in a run mode with idle-enable 0 (and no wake) moves the block to mode 5. There both clock enables are 0.
- R7: A wake event in mode 2, 3 or 5 moves the block to mode 4 on the next cycle. Mode 4 lasts exactly WAKE_DLY cycles, with the CPU enable 0 and the peripheral enable 1. It is followed by mode 0 or mode 1, according to the oscillator used before the wake.
- R8: Changes of the select field or the idle-enable input during modes 2 to 5 have no effect on the source, the status flags or the mode reached after waking. The secondary oscillator keeps running through and after a wake from secondary idle.
- R9: A wake event in the same cycle as a sleep strobe in a run mode is not lost: the block goes directly to mode 4 and resumes after the delay.
- R10: A sleep strobe outside the run modes is ignored. A wake event inside a run mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (stands for the selected oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | One-cycle strobe from the executed sleep instruction |
| idle_en_i | input | 1 | Idle-enable control bit: 1 selects idle, 0 selects sleep |
| clk_sel_i | input | 2 | Clock-source select field, 2'b01 is the secondary oscillator |
| wake_i | input | 1 | Wake event |
| mode_o | output | 3 | Current power mode code |
| cpu_clk_en | output | 1 | Synchronous enable for the CPU clock |
| periph_clk_en | output | 1 | Synchronous enable for the peripheral clock |
| periph_src_sec | output | 1 | 1 when the secondary oscillator is the clock source |
| prim_osc_en | output | 1 | Enable for the primary oscillator |
| osc_ready | output | 1 | Primary oscillator start-up complete flag |
| sec_running | output | 1 | Secondary oscillator running flag |

## Verification
The bench builds the block with WAKE_DLY set to 3 instead of the default 4. This keeps every waking window short, so randomly timed wake events, sleep strobes and select changes land many times in all six modes and at both ends of the delay. Directed sequences cover entry into each idle variant, select changes during idle and during the delay, a sleep strobe arriving together with a wake, and stray strobes in the wrong modes.

// File: rtl/idle_clk_pkg.sv
// Package: shared mode encoding and select constants for the idle clock controller.
// Assumes: the select value 2'b01 names the secondary oscillator; other values map to primary.
package idle_clk_pkg;

    typedef enum logic [2:0] {
        M_PRI_RUN  = 3'd0,
        M_SEC_RUN  = 3'd1,
        M_PRI_IDLE = 3'd2,
        M_SEC_IDLE = 3'd3,
        M_WAKING   = 3'd4,
        M_SLEEP    = 3'd5
    } pm_mode_e;

    localparam logic [1:0] SEL_SEC = 2'b01;

endpackage

// File: rtl/wake_delay_ctr.sv
// Module: wake delay down-counter.
// Loads WAKE_DLY-1 when a wake starts and counts down while decrement is asserted.
// Assumes: WAKE_DLY >= 1; done_o is high whenever the count is zero.
module wake_delay_ctr #(
    parameter int WAKE_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic done_o
);

    localparam int CNT_W = (WAKE_DLY > 1) ? $clog2(WAKE_DLY) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAKE_DLY - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load on wake start, otherwise step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Completion flag for the mode sequencer.
    always_comb begin
        done_o = (cnt_q == '0);
    end

endmodule

// File: rtl/idle_mode_fsm.sv
// Module: power mode sequencer.
// Tracks run, idle, sleep and waking modes and the oscillator in use.
// Assumes: sleep_i is a one-cycle strobe; the source only changes in a run mode.
module idle_mode_fsm
    import idle_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       idle_en_i,
    input  logic [1:0] clk_sel_i,
    input  logic       wake_i,
    input  logic       dly_done_i,
    output pm_mode_e   mode_o,
    output logic       src_sec_o,
    output logic       wake_start_o,
    output logic       dly_dec_o
);

    pm_mode_e state_q, state_d;
    logic     src_q, src_d;
    logic     in_run, in_rest, want_sec;

    // Classify the present mode and the requested source.
    always_comb begin
        in_run   = (state_q == M_PRI_RUN) || (state_q == M_SEC_RUN);
        in_rest  = (state_q == M_PRI_IDLE) || (state_q == M_SEC_IDLE) ||
                   (state_q == M_SLEEP);
        want_sec = (clk_sel_i == SEL_SEC);
    end

    // Next-mode and next-source decision.
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        if (in_run) begin
            src_d = want_sec;
            if (sleep_i) begin
                if (wake_i) begin
                    state_d = M_WAKING;
                end else if (idle_en_i) begin
                    state_d = want_sec ? M_SEC_IDLE : M_PRI_IDLE;
                end else begin
                    state_d = M_SLEEP;
                end
            end else begin
                state_d = want_sec ? M_SEC_RUN : M_PRI_RUN;
            end
        end else if (in_rest) begin
            if (wake_i) begin
                state_d = M_WAKING;
            end
        end else if (state_q == M_WAKING) begin
            if (dly_done_i) begin
                state_d = src_q ? M_SEC_RUN : M_PRI_RUN;
            end
        end else begin
            state_d = M_PRI_RUN;
        end
    end

    // Mode and source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_PRI_RUN;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // Controls for the delay counter and the outward mode.
    always_comb begin
        wake_start_o = (state_d == M_WAKING) && (state_q != M_WAKING);
        dly_dec_o    = (state_q == M_WAKING);
        mode_o       = state_q;
        src_sec_o    = src_q;
    end

endmodule

// File: rtl/clk_en_decode.sv
// Module: clock enable and status decode.
// Turns the mode and source into clock enables, oscillator control and flags.
// Assumes: the source input is stable outside run modes.
module clk_en_decode
    import idle_clk_pkg::*;
(
    input  pm_mode_e mode_i,
    input  logic     src_sec_i,
    output logic     cpu_clk_en,
    output logic     periph_clk_en,
    output logic     periph_src_sec,
    output logic     prim_osc_en,
    output logic     osc_ready,
    output logic     sec_running
);

    // Enables: CPU only in run modes, peripherals everywhere but sleep.
    always_comb begin
        cpu_clk_en    = (mode_i == M_PRI_RUN) || (mode_i == M_SEC_RUN);
        periph_clk_en = (mode_i != M_SLEEP);
    end

    // Oscillator control and status flags follow the source in use.
    always_comb begin
        periph_src_sec = src_sec_i;
        prim_osc_en    = !src_sec_i;
        osc_ready      = !src_sec_i;
        sec_running    = src_sec_i;
    end

endmodule

// File: rtl/idle_clk_ctrl.sv
// Module: idle-mode clock gating controller (top).
// Ties the mode sequencer, wake delay counter and enable decode together.
// Assumes: clk is the currently selected oscillator; reset is synchronous, active low.
module idle_clk_ctrl
    import idle_clk_pkg::*;
#(
    parameter int WAKE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       idle_en_i,
    input  logic [1:0] clk_sel_i,
    input  logic       wake_i,
    output logic [2:0] mode_o,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       periph_src_sec,
    output logic       prim_osc_en,
    output logic       osc_ready,
    output logic       sec_running
);

    pm_mode_e mode_w;
    logic     src_sec_w, wake_start_w, dly_dec_w, dly_done_w;

    idle_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .idle_en_i    (idle_en_i),
        .clk_sel_i    (clk_sel_i),
        .wake_i       (wake_i),
        .dly_done_i   (dly_done_w),
        .mode_o       (mode_w),
        .src_sec_o    (src_sec_w),
        .wake_start_o (wake_start_w),
        .dly_dec_o    (dly_dec_w)
    );

    wake_delay_ctr #(.WAKE_DLY(WAKE_DLY)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wake_start_w),
        .dec_i  (dly_dec_w),
        .done_o (dly_done_w)
    );

    clk_en_decode u_dec (
        .mode_i         (mode_w),
        .src_sec_i      (src_sec_w),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .periph_src_sec (periph_src_sec),
        .prim_osc_en    (prim_osc_en),
        .osc_ready      (osc_ready),
        .sec_running    (sec_running)
    );

    // Outward mode code.
    always_comb begin
        mode_o = mode_w;
    end

endmodule

// File: rtl/idle_clk_ctrl_chk.sv
// Module: property checker for the idle clock controller, bound to the top.
// Assumes: mode codes as in the package; waking windows counted here, not unrolled.
module idle_clk_ctrl_chk #(
    parameter int WAKE_DLY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_i,
    input logic       idle_en_i,
    input logic       wake_i,
    input logic [2:0] mode_o,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       prim_osc_en,
    input logic       osc_ready,
    input logic       sec_running
);

    logic        run_m, rest_m;
    logic [31:0] wait_cnt;

    // Mode classes seen at the ports.
    always_comb begin
        run_m  = (mode_o == 3'd0) || (mode_o == 3'd1);
        rest_m = (mode_o == 3'd2) || (mode_o == 3'd3) || (mode_o == 3'd5);
    end

    // Number of earlier consecutive waking cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (mode_o == 3'd4) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= '0;
        end
    end

    p_sec_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_running |-> (!prim_osc_en && !osc_ready));

    p_idle_cpu_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rest_m |-> !cpu_clk_en);

    p_sleep_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_m && sleep_i && !idle_en_i && !wake_i) |=> (mode_o == 3'd5 && !periph_clk_en));

    p_wake_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_m && wake_i) |=> (mode_o == 3'd4));

    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> (wait_cnt < WAKE_DLY && periph_clk_en && !cpu_clk_en));

    p_src_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 || mode_o == 3'd3 || mode_o == 3'd4) |=> $stable(sec_running));

    p_both_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_m && sleep_i && wake_i) |=> (mode_o == 3'd4));

endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk #(.WAKE_DLY(WAKE_DLY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .idle_en_i     (idle_en_i),
    .wake_i        (wake_i),
    .mode_o        (mode_o),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .prim_osc_en   (prim_osc_en),
    .osc_ready     (osc_ready),
    .sec_running   (sec_running)
);

// File: tb/idle_clk_ctrl_tb.sv
// Bench: directed corner cases plus seeded random stimulus against a requirement model.
module idle_clk_ctrl_tb;

    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       idle_en_i = 1'b0;
    logic [1:0] clk_sel_i = 2'b00;
    logic       wake_i = 1'b0;
    logic [2:0] mode_o;
    logic       cpu_clk_en, periph_clk_en, periph_src_sec;
    logic       prim_osc_en, osc_ready, sec_running;

    int checks = 0;
    int fails  = 0;
    int ms     = 0;
    bit msrc   = 1'b0;
    int mcnt   = 0;

    idle_clk_ctrl #(.WAKE_DLY(DLY)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_i        (sleep_i),
        .idle_en_i      (idle_en_i),
        .clk_sel_i      (clk_sel_i),
        .wake_i         (wake_i),
        .mode_o         (mode_o),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .periph_src_sec (periph_src_sec),
        .prim_osc_en    (prim_osc_en),
        .osc_ready      (osc_ready),
        .sec_running    (sec_running)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Requirement model: next mode from R2, R4-R7, R9, R10.
    function automatic void model_step(bit sl, bit ie, bit [1:0] cs, bit wk);
        bit ws;
        ws = (cs == 2'b01);
        if (ms == 0 || ms == 1) begin
            msrc = ws;
            if (sl) begin
                if (wk) begin ms = 4; mcnt = DLY; end
                else if (ie) ms = ws ? 3 : 2;
                else ms = 5;
            end else begin
                ms = ws ? 1 : 0;
            end
        end else if (ms == 4) begin
            mcnt--;
            if (mcnt == 0) ms = msrc ? 1 : 0;
        end else if (wk) begin
            ms = 4;
            mcnt = DLY;
        end
    endfunction

    function automatic string tag_of(int m);
        case (m)
            0, 1:    return "R2";
            2:       return "R4";
            3:       return "R5";
            4:       return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check_all();
        string t;
        t = tag_of(ms);
        chk({t, " mode"}, int'(mode_o), ms);
        chk({t, " cpu_en"}, int'(cpu_clk_en), (ms <= 1) ? 1 : 0);
        chk({t, " periph_en"}, int'(periph_clk_en), (ms != 5) ? 1 : 0);
        chk("R3 src", int'(periph_src_sec), int'(msrc));
        chk("R3 prim_osc_en", int'(prim_osc_en), int'(!msrc));
        chk("R3 osc_ready", int'(osc_ready), int'(!msrc));
        chk("R3 sec_running", int'(sec_running), int'(msrc));
    endtask

    task automatic step(input bit sl, input bit ie, input bit [1:0] cs, input bit wk);
        sleep_i   = sl;
        idle_en_i = ie;
        clk_sel_i = cs;
        wake_i    = wk;
        @(posedge clk);
        model_step(sl, ie, cs, wk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 mode", int'(mode_o), 0);
        chk("R1 cpu_en", int'(cpu_clk_en), 1);
        chk("R1 periph_en", int'(periph_clk_en), 1);
        chk("R1 prim_osc_en", int'(prim_osc_en), 1);
        chk("R1 osc_ready", int'(osc_ready), 1);
        chk("R1 sec_running", int'(sec_running), 0);

        // R2/R3: run source switching, including select 2'b10 mapping to primary
        step(0, 0, 2'b01, 0);
        chk("R3 on secondary", int'(sec_running), 1);
        step(0, 0, 2'b10, 0);
        chk("R2 select 10 primary", int'(mode_o), 0);

        // R10: wake in run ignored
        step(0, 0, 2'b00, 1);
        chk("R10 wake in run", int'(mode_o), 0);

        // R4 then R8/R10 inside primary idle, then R7 wake
        step(1, 1, 2'b00, 0);
        chk("R4 primary idle", int'(mode_o), 2);
        step(0, 0, 2'b01, 0);
        chk("R8 select ignored in idle", int'(osc_ready), 1);
        step(1, 1, 2'b01, 0);
        chk("R10 sleep in idle", int'(mode_o), 2);
        step(0, 1, 2'b01, 1);
        for (int i = 1; i < DLY; i++) step(0, 1, 2'b01, 0);
        chk("R7 still waking", int'(cpu_clk_en), 0);
        step(0, 1, 2'b01, 0);
        chk("R8 resumes on primary", int'(mode_o), 0);

        // R5: secondary idle and wake keeps secondary
        step(0, 1, 2'b01, 0);
        step(1, 1, 2'b01, 0);
        chk("R5 secondary idle", int'(mode_o), 3);
        step(0, 1, 2'b00, 1);
        for (int i = 0; i < DLY; i++) step(0, 0, 2'b00, 0);
        chk("R8 resumes on secondary", int'(mode_o), 1);
        chk("R8 secondary kept", int'(sec_running), 1);

        // R6: full sleep and wake
        step(1, 0, 2'b00, 0);
        chk("R6 sleep periph", int'(periph_clk_en), 0);
        step(0, 0, 2'b00, 1);
        chk("R7 wake from sleep", int'(mode_o), 4);
        for (int i = 0; i < DLY; i++) step(0, 0, 2'b00, 0);

        // R9: sleep and wake together
        step(1, 1, 2'b00, 1);
        chk("R9 direct to waking", int'(mode_o), 4);
        for (int i = 0; i < DLY; i++) step(0, 0, 2'b00, 0);
        chk("R9 resumed", int'(mode_o), 0);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) == 0, $urandom % 2, 2'($urandom % 4), ($urandom % 6) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule